// File: doc/BRIEF.md
# ITU-R 656 Stream Receiver Filter

This block sits behind a parallel video input port and takes a stream of ITU-R 656 elements, one element per accepted input cycle. The elements are 8 or 10 bits wide. The block finds the timing reference sequences embedded in the stream. Each sequence is a run of three fixed values followed by a control word. From that control word the block reads the field bit, the vertical blanking bit and the bit that tells an end-of-video marker from a start-of-video marker. It then keeps or drops each element according to the chosen capture mode.

There are three capture modes. The first keeps only active picture samples on lines outside vertical blanking. The second keeps everything on vertical blanking lines, including the horizontal blanking and the timing sequences on those lines. The third keeps the whole field. Kept elements leave on a valid/data output with their order unchanged. A start-of-line pulse and a start-of-field pulse mark the line and field boundaries, and a level output gives the current field.

Every element is held back by three positions. This lets a whole four-element timing sequence be classified before its first element leaves. Configuration inputs are expected to change only while reset is asserted.

Top module: `vid656_rx_filter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid`, `out_sol`, `out_sof`, `out_field` and `out_data` are all zero.
- R2: With `cfg_wide`=0, elements are 8 bits wide. `in_data[9:8]` is ignored, `out_data[9:8]` is zero, the all-ones value is 0xFF, and control-word bits 7,6,5,4 are leading-one, F, V, H. With `cfg_wide`=1, elements are 10 bits wide, the all-ones value is 0x3FF, and bits 9,8,7,6 carry leading-one, F, V, H.
- R3: A timing sequence is recognised only as all-ones, zero, zero, followed by a word whose leading-one bit is set. If the leading-one bit is clear, all four elements are treated as ordinary data.
- R4: In `cfg_mode`=0 (active picture), an ordinary element is kept only if the most recent control word was a start marker (H=0) with V=0. All four elements of every timing sequence are dropped.
- R5: In `cfg_mode`=1 (vertical blanking), an ordinary element is kept only if the most recent control word had V=1. A timing sequence is kept as a whole exactly when its own control word has V=1.
- R6: In `cfg_mode`=2 and `cfg_mode`=3 (whole field), every element is kept, including the timing sequences.
- R7: Kept elements leave in input order. An element is presented on the clock edge that accepts the element three positions after it.
- R8: `out_sol` pulses for one cycle when the control word of a start marker (H=0) leaves the hold-back stage, whether or not that word is kept.
- R9: `out_sof` pulses together with `out_sol` when the start marker's F differs from `out_field`. On that same edge `out_field` takes the new F. At no other time does `out_field` change. Its value after reset is 0.
- R10: `out_valid` is high only in the cycle after an accepted input (`in_valid` high), and the number of kept elements matches the mode rules exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wide | input | 1 | 1 selects 10-bit elements, 0 selects 8-bit |
| cfg_mode | input | 2 | Capture mode: 0 active picture, 1 vertical blanking, 2 or 3 whole field |
| in_valid | input | 1 | An element is offered this cycle |
| in_data | input | 10 | Incoming element |
| out_valid | output | 1 | A kept element is on `out_data` |
| out_data | output | 10 | Kept element, upper bits zero in 8-bit mode |
| out_sol | output | 1 | One-cycle start-of-line pulse |
| out_sof | output | 1 | One-cycle start-of-field pulse |
| out_field | output | 1 | Field bit taken from the last start marker that changed it |

## Verification
On every cycle, the assertions check the following: output valid and line pulses appear only after an accepted element; the upper output bits stay clear in 8-bit mode; a field pulse only comes with a line pulse and always flips the field level; and the field level holds between such pulses. Some behaviours can only be shown by the bench's sweeps over both widths and all four mode codes, each with a multi-line frame of known blanking lines and field changes. These are: which elements each mode keeps, their order and latency, the rejection of a false sequence without the leading one, and the exact counts of line and field pulses.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

    localparam int unsigned ELEM_W   = 10;
    localparam int unsigned NARROW_W = 8;
    localparam int unsigned HOLD_LEN = 3;

    typedef enum logic [1:0] {
        CAP_ACTIVE    = 2'd0,
        CAP_VBI       = 2'd1,
        CAP_FIELD     = 2'd2,
        CAP_FIELD_ALT = 2'd3
    } cap_mode_e;

    typedef enum logic [1:0] {
        EL_DATA   = 2'd0,
        EL_PREFIX = 2'd1,
        EL_CTRL   = 2'd2
    } el_kind_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trs_flags_t;

    function automatic logic [ELEM_W-1:0] elem_mask(input logic wide);
        return wide ? {ELEM_W{1'b1}} : {{(ELEM_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endfunction

    function automatic logic [ELEM_W-1:0] all_ones(input logic wide);
        return elem_mask(wide);
    endfunction

    function automatic logic lead_set(input logic [ELEM_W-1:0] x, input logic wide);
        return wide ? x[ELEM_W-1] : x[NARROW_W-1];
    endfunction

    // R2: F, V, H sit just below the leading one
    function automatic trs_flags_t decode_trs(input logic [ELEM_W-1:0] x, input logic wide);
        trs_flags_t t;
        if (wide) begin
            t.f = x[ELEM_W-2];
            t.v = x[ELEM_W-3];
            t.h = x[ELEM_W-4];
        end else begin
            t.f = x[NARROW_W-2];
            t.v = x[NARROW_W-3];
            t.h = x[NARROW_W-4];
        end
        return t;
    endfunction

endpackage

// File: rtl/vid656_trs_window.sv
module vid656_trs_window
    import vid656_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              in_valid,
    input  logic [ELEM_W-1:0] in_data,
    output logic              ex_valid,
    output logic [ELEM_W-1:0] ex_data,
    output el_kind_e          ex_kind,
    output trs_flags_t        ex_flags
);
    localparam int unsigned TOP = HOLD_LEN - 1;

    logic [ELEM_W-1:0] dat [HOLD_LEN];
    el_kind_e          tag [HOLD_LEN];
    logic [HOLD_LEN-1:0] vld;
    trs_flags_t        grp;
    logic [ELEM_W-1:0] x;
    logic              prefix_ok;
    logic              pre_hit;

    assign x = in_data & elem_mask(wide);

    // R3: held elements are all-ones, zero, zero and the new word has its leading one
    always_comb begin
        prefix_ok = (&vld) && (dat[TOP] == all_ones(wide));
        for (int i = 0; i < int'(HOLD_LEN); i++) begin
            if (tag[i] != EL_DATA) prefix_ok = 1'b0;
            if (i < int'(TOP) && dat[i] != '0) prefix_ok = 1'b0;
        end
        pre_hit = prefix_ok && lead_set(x, wide);
    end

    always_comb begin
        ex_valid = in_valid && vld[TOP];
        ex_data  = dat[TOP];
        if (pre_hit) begin
            ex_kind  = EL_PREFIX;
            ex_flags = decode_trs(x, wide);
        end else if (tag[TOP] == EL_CTRL) begin
            ex_kind  = EL_CTRL;
            ex_flags = decode_trs(dat[TOP], wide);
        end else begin
            ex_kind  = tag[TOP];
            ex_flags = grp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            grp <= '0;
            for (int i = 0; i < int'(HOLD_LEN); i++) begin
                dat[i] <= '0;
                tag[i] <= EL_DATA;
            end
        end else if (in_valid) begin
            for (int i = TOP; i > 0; i--) begin
                dat[i] <= dat[i-1];
                tag[i] <= pre_hit ? EL_PREFIX : tag[i-1];
                vld[i] <= vld[i-1];
            end
            dat[0] <= x;
            tag[0] <= pre_hit ? EL_CTRL : EL_DATA;
            vld[0] <= 1'b1;
            if (pre_hit) grp <= decode_trs(x, wide);
        end
    end
endmodule

// File: rtl/vid656_capture_gate.sv
module vid656_capture_gate
    import vid656_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              ex_valid,
    input  logic [ELEM_W-1:0] ex_data,
    input  el_kind_e          ex_kind,
    input  trs_flags_t        ex_flags,
    output logic              out_valid,
    output logic [ELEM_W-1:0] out_data,
    output logic              out_sol,
    output logic              out_sof,
    output logic              out_field
);
    cap_mode_e cmode;
    logic      in_act;
    logic      vflag;
    logic      keep;
    logic      is_sav;

    assign cmode  = cap_mode_e'(mode);
    assign is_sav = ex_valid && (ex_kind == EL_CTRL) && !ex_flags.h;

    // R4, R5, R6: capture rules
    always_comb begin
        if (ex_kind == EL_DATA) begin
            case (cmode)
                CAP_ACTIVE: keep = in_act && !vflag;
                CAP_VBI:    keep = vflag;
                default:    keep = 1'b1;
            endcase
        end else begin
            case (cmode)
                CAP_ACTIVE: keep = 1'b0;
                CAP_VBI:    keep = ex_flags.v;
                default:    keep = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_act    <= 1'b0;
            vflag     <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sol   <= 1'b0;
            out_sof   <= 1'b0;
            out_field <= 1'b0;
        end else begin
            out_valid <= ex_valid && keep;
            out_data  <= ex_data;
            out_sol   <= is_sav;
            out_sof   <= is_sav && (ex_flags.f != out_field);
            if (ex_valid && ex_kind == EL_CTRL) begin
                vflag  <= ex_flags.v;
                in_act <= !ex_flags.h;
            end
            if (is_sav) out_field <= ex_flags.f;
        end
    end
endmodule

// File: rtl/vid656_rx_filter.sv
module vid656_rx_filter
    import vid656_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wide,
    input  logic [1:0]        cfg_mode,
    input  logic              in_valid,
    input  logic [ELEM_W-1:0] in_data,
    output logic              out_valid,
    output logic [ELEM_W-1:0] out_data,
    output logic              out_sol,
    output logic              out_sof,
    output logic              out_field
);
    logic              ex_valid;
    logic [ELEM_W-1:0] ex_data;
    el_kind_e          ex_kind;
    trs_flags_t        ex_flags;

    vid656_trs_window u_window (
        .clk      (clk),
        .rst      (rst),
        .wide     (cfg_wide),
        .in_valid (in_valid),
        .in_data  (in_data),
        .ex_valid (ex_valid),
        .ex_data  (ex_data),
        .ex_kind  (ex_kind),
        .ex_flags (ex_flags)
    );

    vid656_capture_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_mode),
        .ex_valid  (ex_valid),
        .ex_data   (ex_data),
        .ex_kind   (ex_kind),
        .ex_flags  (ex_flags),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sol   (out_sol),
        .out_sof   (out_sof),
        .out_field (out_field)
    );
endmodule

// File: rtl/vid656_rx_checker.sv
module vid656_rx_checker
    import vid656_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_wide,
    input logic              in_valid,
    input logic              out_valid,
    input logic [ELEM_W-1:0] out_data,
    input logic              out_sol,
    input logic              out_sof,
    input logic              out_field
);
    assert_valid_follows_input_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_sol_follows_input_R8: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> $past(in_valid));

    assert_narrow_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !cfg_wide) |-> (out_data[ELEM_W-1:NARROW_W] == '0));

    assert_sof_with_sol_R9: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_sol);

    assert_field_flips_on_sof_R9: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> (out_field != $past(out_field)));

    assert_field_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !out_sof |-> $stable(out_field));
endmodule

bind vid656_rx_filter vid656_rx_checker u_chk (.*);

// File: tb/vid656_rx_filter_tb.sv
module vid656_rx_filter_tb;
    import vid656_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wide = 1'b0;
    logic [1:0]        cfg_mode = 2'd0;
    logic              in_valid = 1'b0;
    logic [ELEM_W-1:0] in_data = '0;
    logic              out_valid;
    logic [ELEM_W-1:0] out_data;
    logic              out_sol;
    logic              out_sof;
    logic              out_field;

    always #4 clk = ~clk;

    vid656_rx_filter u_dut (.*);

    int checks = 0;
    int fails  = 0;
    int exp_d [0:511];
    int obs_d [0:511];
    int exp_n, obs_n, sol_n, sof_n, sof_hi_n;
    int exp_sol, exp_sof, exp_sof_hi;
    int gap;
    bit cur_v, cur_act, last_f;
    logic prev_in = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) prev_in <= in_valid;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                check(prev_in, "R10 valid without input", 1, 0);
                if (obs_n < 512) obs_d[obs_n] = int'(out_data);
                obs_n++;
            end
            if (out_sol) sol_n++;
            if (out_sof) begin
                sof_n++;
                if (out_field) sof_hi_n++;
            end
        end
    end

    function automatic bit keep_data();
        case (cfg_mode)
            2'd0:    return cur_act && !cur_v;
            2'd1:    return cur_v;
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit keep_trs(input bit v);
        case (cfg_mode)
            2'd0:    return 1'b0;
            2'd1:    return v;
            default: return 1'b1;
        endcase
    endfunction

    task automatic drive(input int raw);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = raw[ELEM_W-1:0];
        gap++;
        if (gap % 3 == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // value is the expected output; 8-bit runs add junk in the upper input bits (R2)
    task automatic elem(input int value, input bit counted, input bit keep);
        int raw;
        raw = cfg_wide ? value : (value | 'h300);
        drive(raw);
        if (counted && keep) begin
            exp_d[exp_n] = value;
            exp_n++;
        end
    endtask

    task automatic trs(input bit f, input bit v, input bit h);
        int ones, cw;
        bit k;
        ones = cfg_wide ? 'h3FF : 'hFF;
        cw = cfg_wide ? ((1 << 9) | (int'(f) << 8) | (int'(v) << 7) | (int'(h) << 6) | (5 << 2))
                      : ('h80 | (int'(f) << 6) | (int'(v) << 5) | (int'(h) << 4) | 5);
        k = keep_trs(v);
        elem(ones, 1, k);
        elem(0, 1, k);
        elem(0, 1, k);
        elem(cw, 1, k);
        cur_v   = v;
        cur_act = !h;
        if (!h) begin
            exp_sol++;
            if (f != last_f) begin
                exp_sof++;
                if (f) exp_sof_hi++;
                last_f = f;
            end
        end
    endtask

    task automatic sample(input int base);
        elem(cfg_wide ? base + 'h200 : base, 1, keep_data());
    endtask

    task automatic run(input bit wide, input int mode);
        string req;
        bit found;
        req = (mode == 0) ? "R4" : (mode == 1) ? "R5" : "R6";
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        cfg_wide = wide;
        cfg_mode = mode[1:0];
        exp_n = 0; obs_n = 0; sol_n = 0; sof_n = 0; sof_hi_n = 0;
        exp_sol = 0; exp_sof = 0; exp_sof_hi = 0; gap = 0;
        cur_v = 0; cur_act = 0; last_f = 0;
        repeat (3) @(negedge clk);
        check({out_valid, out_sol, out_sof, out_field, out_data} == '0, "R1 reset outputs",
              int'({out_valid, out_sol, out_sof, out_field, out_data}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({out_valid, out_sol, out_sof, out_field, out_data} == '0, "R1 after release",
              int'({out_valid, out_sol, out_sof, out_field, out_data}), 0);
        for (int line = 0; line < 8; line++) begin
            bit f, v;
            f = (line >= 3 && line <= 5);
            v = (line == 0 || line == 3 || line == 6);
            trs(f, v, 1'b1);
            for (int i = 0; i < 3; i++) sample('h10 + line * 4 + i);
            trs(f, v, 1'b0);
            for (int i = 0; i < 4; i++) begin
                sample('h40 + line * 5 + i);
                if (line == 4 && i == 1) begin
                    // R3: leading one clear, so these four are plain data
                    elem(cfg_wide ? 'h3FF : 'hFF, 1, keep_data());
                    elem(0, 1, keep_data());
                    elem(0, 1, keep_data());
                    elem(5, 1, keep_data());
                end
            end
        end
        for (int i = 0; i < 3; i++) elem('h11, 0, 0);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);

        check(obs_n == exp_n, {req, " R10 kept count"}, obs_n, exp_n);
        for (int i = 0; i < exp_n && i < obs_n && i < 512; i++) begin
            check(obs_d[i] == exp_d[i], {req, " R7 element"}, obs_d[i], exp_d[i]);
            if (!wide) check(obs_d[i] < 'h100, "R2 upper bits", obs_d[i], obs_d[i] & 'hFF);
        end
        if (mode == 0) begin
            found = 0;
            for (int i = 0; i < obs_n && i < 512; i++) if (obs_d[i] == 5) found = 1;
            check(found, "R3 false sequence kept as data", int'(found), 1);
        end
        check(sol_n == exp_sol, "R8 line pulses", sol_n, exp_sol);
        check(sof_n == exp_sof, "R9 field pulses", sof_n, exp_sof);
        check(sof_hi_n == exp_sof_hi, "R9 field pulses into F=1", sof_hi_n, exp_sof_hi);
        check(out_field == last_f, "R9 final field", int'(out_field), int'(last_f));
    endtask

    initial begin
        for (int w = 0; w < 2; w++)
            for (int m = 0; m < 4; m++)
                run(w[0], m);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule